// File: doc/BRIEF.md
# Serial-Flash Hold Controller

This block sits at the front of a serial-flash slave interface. It decides when the serial link is paused by the active-low hold pin. All slave-side pins (select, serial clock, hold, data-in) are asynchronous to the fast system clock that runs the block. Each is brought in through a multi-stage synchronizer, and the serial clock is handled as a sampled level with an edge detector. From these levels a small control machine works out whether the link is running, paused, idle, or locked out after an abnormal deselect.

The control machine drives a strobe bundle into a datapath. The datapath assembles received bits into words, most significant bit first. The strobes freeze that datapath across a pause, so a partly received command resumes exactly where it stopped. The block also gives a data-out drive enable, a hold flag, and a one-cycle interface reset. The reset fires when the device is deselected in the middle of a pause. After that reset the link stays locked until hold has been released while deselected. A busy level from the program/erase engine passes straight through and is never gated by the hold state.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, holdActive, doOe, ifReset, shiftEn and wordValid are all 0.
- R2: While chip select (csN) is high, a low holdN never sets holdActive.
- R3: With the device selected and sck low, a falling holdN sets holdActive within the synchronizer latency (at most 5 system clocks).
- R4: With the device selected and sck high, a falling holdN leaves holdActive at 0 until sck goes low, then sets it.
- R5: During hold with sck low, a rising holdN clears holdActive within 5 system clocks.
- R6: During hold with sck high, a rising holdN leaves holdActive at 1 until sck goes low, then clears it.
- R7: doOe is 1 only while the device is selected, running and not held. It is 0 during hold, while idle and while locked out.
- R8: While held, sck edges and dataIn values give no shiftEn and leave the partial word untouched. Bits sent before and after the pause join into one word.
- R9: engBusyOut always equals engBusyIn, in every hold state.
- R10: csN rising while holdActive is 1 gives exactly one ifReset cycle and clears holdActive. It also discards the partial word.
- R11: After an R10 reset, selecting the device again has no effect (doOe 0, no shiftEn) until holdN has been high while csN is high. Only the next csN fall restarts the link.
- R12: Bits are taken on sck rising edges outside hold, the first bit landing in the most significant position. After WORD_W (default 8) such bits, wordValid pulses for one cycle with the word on wordOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sck |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| holdN | input | 1 | Hold request, active low |
| dataIn | input | 1 | Serial data in |
| engBusyIn | input | 1 | Busy from program/erase engine |
| engBusyOut | output | 1 | Busy passed through unchanged |
| holdActive | output | 1 | Link is paused |
| doOe | output | 1 | Data-out drive enable (0 = high impedance) |
| shiftEn | output | 1 | One-cycle strobe per accepted bit |
| rxBit | output | 1 | Synchronized data-in, valid with shiftEn |
| ifReset | output | 1 | One-cycle interface reset pulse |
| wordOut | output | WORD_W | Last assembled word |
| wordValid | output | 1 | One-cycle strobe when wordOut is new |

## Verification
Hold is applied against each phase of the serial clock. A hold fall and a hold rise are each tried with sck low, where they must act at once, and with sck high, where they must wait for the next low phase. Comparing these cases shows whether the block gates on the clock level. Clock pulses sent during a pause, and words cut in two by a pause, show whether the shift position is frozen rather than reset. A deselect in mid-pause, followed by reselection with hold still low, then hold released while selected, then the proper release order, tells the lockout sequence apart from a plain reselect.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_HOLD   = 2'd2,
    ST_LOCK   = 2'd3
  } linkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;   // accept one bit
    logic clear;   // drop partial word
    logic held;    // pause in force
  } ctlStrb_t;

  // synchronized pin view from datapath to control
  typedef struct packed {
    logic csHigh;
    logic sckHigh;
    logic holdHigh;
    logic sckRise;
  } pinView_t;

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[0] <= RST_VAL;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= RST_VAL;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/spi_hold_datapath.sv
module spi_hold_datapath
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 8,
  localparam int CNT_W      = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              holdN,
  input  logic              dataIn,
  input  ctlStrb_t          strb,
  output pinView_t          pins,
  output logic              rxBit,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [3:0] syncQ;
  logic       sckPrev;
  logic [WORD_W-1:0] shiftQ;
  logic [CNT_W-1:0]  bitCnt;

  // order: csN, sck, holdN, dataIn ; idle levels 1,0,1,0
  spi_hold_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (4),
    .RST_VAL(4'b1010)
  ) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({csN, sck, holdN, dataIn}),
    .syncOut(syncQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= syncQ[2];
  end

  assign pins.csHigh   = syncQ[3];
  assign pins.sckHigh  = syncQ[2];
  assign pins.holdHigh = syncQ[1];
  assign pins.sckRise  = syncQ[2] & ~sckPrev;
  assign rxBit         = syncQ[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ    <= '0;
      bitCnt    <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (strb.clear) begin
        shiftQ <= '0;
        bitCnt <= '0;
      end else if (strb.shift) begin
        shiftQ <= {shiftQ[WORD_W-2:0], syncQ[0]};
        if (bitCnt == LAST_BIT) begin
          bitCnt    <= '0;
          wordOut   <= {shiftQ[WORD_W-2:0], syncQ[0]};
          wordValid <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R8
  frozen_in_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.held && $past(strb.held)) |-> ($stable(bitCnt) && $stable(shiftQ)));

  // R12
  word_after_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $past(strb.shift));

endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  pinView_t pins,
  output ctlStrb_t strb,
  output logic     holdActive,
  output logic     doOe,
  output logic     shiftEn,
  output logic     ifReset
);

  linkState_t state, nextState;
  logic       rstPulse;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (!pins.csHigh) nextState = ST_ACTIVE;
      ST_ACTIVE: begin
        if (pins.csHigh)                              nextState = ST_IDLE;
        else if (!pins.holdHigh && !pins.sckHigh)     nextState = ST_HOLD;
      end
      ST_HOLD: begin
        if (pins.csHigh)                              nextState = ST_LOCK;
        else if (pins.holdHigh && !pins.sckHigh)      nextState = ST_ACTIVE;
      end
      ST_LOCK:   if (pins.csHigh && pins.holdHigh) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rstPulse <= 1'b0;
    end else begin
      state    <= nextState;
      rstPulse <= (state == ST_HOLD) && pins.csHigh;
    end
  end

  assign holdActive  = (state == ST_HOLD);
  assign doOe        = (state == ST_ACTIVE);
  assign shiftEn     = (state == ST_ACTIVE) && !pins.csHigh && pins.sckRise;
  assign ifReset     = rstPulse;
  assign strb.shift  = shiftEn;
  assign strb.held   = holdActive;
  assign strb.clear  = (state == ST_IDLE) || (state == ST_LOCK);

  // R3
  hold_entry_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdActive) |-> $past(!pins.sckHigh && !pins.holdHigh && !pins.csHigh));

  // R6
  hold_exit_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdActive) |-> $past(pins.csHigh || !pins.sckHigh));

  // R8
  no_shift_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdActive |-> !shiftEn);

  // R10
  reset_after_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ifReset |-> ($past(holdActive) && !holdActive));

  // R11
  lock_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state == ST_LOCK) && state != ST_LOCK) |-> $past(pins.csHigh && pins.holdHigh));

  // R7
  oe_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doOe && $past(doOe)) |-> $past(!pins.csHigh));

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              holdN,
  input  logic              dataIn,
  input  logic              engBusyIn,
  output logic              engBusyOut,
  output logic              holdActive,
  output logic              doOe,
  output logic              shiftEn,
  output logic              rxBit,
  output logic              ifReset,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);

  ctlStrb_t strb;
  pinView_t pins;

  spi_hold_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .WORD_W     (WORD_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .sck      (sck),
    .holdN    (holdN),
    .dataIn   (dataIn),
    .strb     (strb),
    .pins     (pins),
    .rxBit    (rxBit),
    .wordOut  (wordOut),
    .wordValid(wordValid)
  );

  spi_hold_fsm uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .pins      (pins),
    .strb      (strb),
    .holdActive(holdActive),
    .doOe      (doOe),
    .shiftEn   (shiftEn),
    .ifReset   (ifReset)
  );

  // busy from the engine is never gated by hold
  assign engBusyOut = engBusyIn;

  // R9
  busy_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdActive |-> (engBusyOut == engBusyIn));

endmodule

// File: tb/spi_hold_ctrl_test.sv
`timescale 1ns/1ps
module spi_hold_ctrl_test;

  localparam int WORD_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, holdN = 1'b1, dataIn = 1'b0, engBusyIn = 1'b0;
  logic engBusyOut, holdActive, doOe, shiftEn, rxBit, ifReset, wordValid;
  logic [WORD_W-1:0] wordOut;

  int checks = 0;
  int fails  = 0;
  int shiftCnt = 0;
  int resetCycles = 0;
  int wordCnt = 0;
  bit finished = 1'b0;

  logic [WORD_W-1:0] expQ [$];
  logic [WORD_W-1:0] modelWord = '0;
  int modelBits = 0;

  always #2 clk = ~clk;

  spi_hold_ctrl #(.WORD_W(WORD_W)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .holdN(holdN),
    .dataIn(dataIn), .engBusyIn(engBusyIn), .engBusyOut(engBusyOut),
    .holdActive(holdActive), .doOe(doOe), .shiftEn(shiftEn), .rxBit(rxBit),
    .ifReset(ifReset), .wordOut(wordOut), .wordValid(wordValid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  // driver: model pushes expected words into the scoreboard
  task automatic noteBit(input logic b);
    modelWord = {modelWord[WORD_W-2:0], b};
    modelBits++;
    if (modelBits == WORD_W) begin
      expQ.push_back(modelWord);
      modelBits = 0;
      modelWord = '0;
    end
  endtask

  task automatic pulseSck(input logic b, input bit counted);
    dataIn = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    if (counted) noteBit(b);
    repeat (6) @(negedge clk);
    sck = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic sendWord(input logic [WORD_W-1:0] w);
    for (int i = WORD_W - 1; i >= 0; i--) pulseSck(w[i], 1'b1);
  endtask

  // monitor: pops and compares
  always @(negedge clk) begin
    if (rstN) begin
      if (shiftEn) shiftCnt++;
      if (ifReset) resetCycles++;
      if (wordValid) begin
        wordCnt++;
        if (expQ.size() == 0) begin
          check(1'b0, "R12 unexpected word", int'(wordOut), -1);
        end else begin
          logic [WORD_W-1:0] e;
          e = expQ.pop_front();
          check(wordOut == e, "R8/R12 word", int'(wordOut), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int snap;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(holdActive == 0 && doOe == 0 && ifReset == 0 && shiftEn == 0 && wordValid == 0,
          "R1 reset outputs", {holdActive, doOe, ifReset, wordValid}, 0);
    rstN = 1'b1;
    settle();
    check(holdActive == 0 && doOe == 0, "R1 after release", {holdActive, doOe}, 0);

    // R2 no hold while deselected
    holdN = 1'b0;
    settle();
    check(holdActive == 0, "R2 hold while deselected", holdActive, 0);
    check(doOe == 0, "R7 idle oe", doOe, 0);
    holdN = 1'b1;
    settle();

    csN = 1'b0;
    settle();
    check(doOe == 1, "R7 selected oe", doOe, 1);
    pulseSck(1, 1); pulseSck(0, 1); pulseSck(1, 1);

    // R3 hold entry with sck low
    holdN = 1'b0;
    settle();
    check(holdActive == 1, "R3 entry sck low", holdActive, 1);
    check(doOe == 0, "R7 oe in hold", doOe, 0);

    // R8 clocks ignored during hold
    snap = shiftCnt;
    pulseSck(1, 0); pulseSck(0, 0);
    check(shiftCnt == snap, "R8 shifts in hold", shiftCnt, snap);

    // R9 busy passthrough in hold
    engBusyIn = 1'b1;
    #1;
    check(engBusyOut == 1, "R9 busy high in hold", engBusyOut, 1);
    engBusyIn = 1'b0;
    #1;
    check(engBusyOut == 0, "R9 busy low in hold", engBusyOut, 0);

    // R5 exit with sck low
    holdN = 1'b1;
    settle();
    check(holdActive == 0, "R5 exit sck low", holdActive, 0);
    check(doOe == 1, "R7 oe after exit", doOe, 1);
    pulseSck(1, 1); pulseSck(1, 1);

    // R4 hold fall with sck high
    dataIn = 1'b0;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    noteBit(1'b0);
    settle();
    holdN = 1'b0;
    settle();
    check(holdActive == 0, "R4 waits while sck high", holdActive, 0);
    sck = 1'b0;
    settle();
    check(holdActive == 1, "R4 entry at sck low", holdActive, 1);

    // R6 hold rise with sck high
    snap = shiftCnt;
    sck = 1'b1;
    settle();
    holdN = 1'b1;
    settle();
    check(holdActive == 1, "R6 stays while sck high", holdActive, 1);
    sck = 1'b0;
    settle();
    check(holdActive == 0, "R6 exit at sck low", holdActive, 0);
    check(shiftCnt == snap, "R8 no shift across hold", shiftCnt, snap);

    pulseSck(0, 1); pulseSck(1, 1);   // completes 0xB9
    sendWord(8'h3C);
    engBusyIn = 1'b1;
    #1;
    check(engBusyOut == 1, "R9 busy while running", engBusyOut, 1);
    engBusyIn = 1'b0;

    // R10 deselect during hold
    pulseSck(1, 1); pulseSck(1, 1); pulseSck(0, 1);
    holdN = 1'b0;
    settle();
    check(holdActive == 1, "R10 in hold", holdActive, 1);
    csN = 1'b1;
    settle();
    check(resetCycles == 1, "R10 reset pulse width", resetCycles, 1);
    check(holdActive == 0, "R10 hold cleared", holdActive, 0);
    modelBits = 0;
    modelWord = '0;

    // R11 lockout
    csN = 1'b0;
    settle();
    check(doOe == 0, "R11 reselect with hold low", doOe, 0);
    snap = shiftCnt;
    pulseSck(1, 0);
    check(shiftCnt == snap, "R11 no shift while locked", shiftCnt, snap);
    holdN = 1'b1;
    settle();
    check(doOe == 0, "R11 hold high while selected", doOe, 0);
    csN = 1'b1;
    settle();
    csN = 1'b0;
    settle();
    check(doOe == 1, "R11 restart after order", doOe, 1);
    sendWord(8'hA5);
    csN = 1'b1;
    settle();

    // R12 word count and empty scoreboard
    check(wordCnt == 3, "R12 word count", wordCnt, 3);
    check(expQ.size() == 0, "R12 scoreboard drained", expQ.size(), 0);
    check(resetCycles == 1, "R10 single reset overall", resetCycles, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule